// File: doc/BRIEF.md
# Bridge Overcurrent Supervisor with Retry or Latch Recovery

This block watches a single overcurrent-detect line shared by several motor bridges and decides when those bridges must be forced into standby. The detect line is asynchronous, so it first passes through a synchronizer. A qualification counter then checks that the condition persists. Only when the condition has been present for a programmable number of consecutive cycles does the supervisor trip. A trip raises a fault flag and a force-standby output that the bridge drivers obey.

Two recovery policies are available, and a policy-select input chooses between them at the moment of the trip. With retry recovery, the bridges are released after a fixed off interval. If the short is still present, the bridges conduct only for the qualification window before the next trip, which gives a repeating hiccup pattern. With latch recovery, the bridges stay in standby until the power-enable input is pulled low. Pulling power-enable low also puts the bridges in standby directly and clears the qualification counter under either policy.

Top module: `ocp_guard`

## Requirements
- R1: While reset is asserted and right after it is released, `fault` is low, and `force_stby` equals the inverse of `pwr_en`.
- R2: A synchronized detect that stays high for no more than `qual_limit` consecutive cycles and then drops causes no trip. The qualification count restarts from zero.
- R3: Suppose `oc_det_raw` rises before clock edge k and stays high while `pwr_en` is high. Then `fault` and `force_stby` are low after edge k+`qual_limit`+1 and high after edge k+`qual_limit`+2. This is SYNC_STAGES=2 synchronizer edges plus `qual_limit`+1 qualification edges.
- R4: Under the retry policy (`latch_sel` low at the trip), `fault` stays high for exactly RETRY_CYCLES cycles and then clears without any other stimulus.
- R5: If detect is still high when a retry releases the bridges, `fault` stays low for exactly `qual_limit`+1 cycles and then rises again.
- R6: Under the latch policy (`latch_sel` high at the trip), `fault` stays high for any length of time, whether detect stays high or clears, until `pwr_en` goes low.
- R7: With `pwr_en` low, `force_stby` is high in the same cycle. A tripped state is cleared at the next edge, so `fault` is low after it. Detect is not qualified while `pwr_en` is low, so no trip occurs however long detect stays high.
- R8: The policy is fixed at the trip. Changing `latch_sel` during a retry off interval does not stop the release. Changing it during a latch does not release the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| oc_det_raw | input | 1 | Asynchronous overcurrent detect from the sense comparator |
| latch_sel | input | 1 | Recovery policy: 0 retry, 1 latch (sampled at trip) |
| pwr_en | input | 1 | Power enable; low means power-save, which forces standby and clears the protection |
| qual_limit | input | QUAL_W | Qualification preload; a trip needs `qual_limit`+1 consecutive synchronized detect cycles |
| force_stby | output | 1 | Standby command to all bridges |
| fault | output | 1 | Protection has tripped and is holding the bridges off |

## Verification
The hardest situation to reach is the hiccup cycle. Detect has to stay asserted across a whole retry off interval, and the bench then has to land on the exact cycle where the bridges come back on and are tripped again. It also has to flip the policy input in the middle of that interval. The stimulus holds the raw detect line high from the first trip through the release. It counts negative edges from the first trip to find the release cycle and the re-trip cycle, using arithmetic in the bench. It does this for every qualification preload of a 4-bit configuration and under both policies.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_RETRY = 2'd1,
    ST_LATCH = 2'd2
  } ocp_state_e;
endpackage

// File: rtl/ocp_sync.sv
// Multi-stage bit synchronizer with asynchronous clear.
module ocp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/ocp_qual.sv
// Counts consecutive detect cycles; trip when the count reaches the limit.
module ocp_qual #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         det,
  input  logic [W-1:0] limit,
  output logic         trip
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  assign trip = det && (cnt_q == limit);

  always_comb begin
    if (clr || !det || trip) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
    cnt_en = clr || det || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocp_hold.sv
// Fixed off-interval timer for the retry policy.
module ocp_hold #(
  parameter int CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign done = run && (cnt_q == LAST);

  always_comb begin
    if (!run || done) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    cnt_en = run || (cnt_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ocp_guard.sv
module ocp_guard
  import ocp_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int QUAL_W       = 8,
  parameter int RETRY_CYCLES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              oc_det_raw,
  input  logic              latch_sel,
  input  logic              pwr_en,
  input  logic [QUAL_W-1:0] qual_limit,
  output logic              force_stby,
  output logic              fault
);
  logic       rst_q_n;
  logic       oc_sync;
  logic       trip;
  logic       hold_done;
  logic       qual_clr;
  ocp_state_e state_q;
  ocp_state_e state_d;

  // Reset: asserted asynchronously, released after SYNC_STAGES edges.
  ocp_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q_n)
  );

  ocp_sync #(.STAGES(SYNC_STAGES)) u_det_sync (
    .clk(clk), .rst_n(rst_q_n), .d(oc_det_raw), .q(oc_sync)
  );

  assign qual_clr = !pwr_en || (state_q != ST_RUN);

  ocp_qual #(.W(QUAL_W)) u_qual (
    .clk(clk), .rst_n(rst_q_n), .clr(qual_clr), .det(oc_sync),
    .limit(qual_limit), .trip(trip)
  );

  ocp_hold #(.CYCLES(RETRY_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_q_n), .run(state_q == ST_RETRY), .done(hold_done)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RUN: begin
        if (pwr_en && trip) state_d = latch_sel ? ST_LATCH : ST_RETRY;
      end
      ST_RETRY: begin
        if (!pwr_en || hold_done) state_d = ST_RUN;
      end
      ST_LATCH: begin
        if (!pwr_en) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= ST_RUN;
    else          state_q <= state_d;
  end

  assign fault      = (state_q != ST_RUN);
  assign force_stby = fault || !pwr_en;
endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk
  import ocp_pkg::*;
#(
  parameter int RETRY_CYCLES = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pwr_en,
  input logic       oc_s,
  input logic       fault,
  input logic       force_stby,
  input ocp_state_e st
);
  localparam int KW = $clog2(RETRY_CYCLES + 2) + 1;
  logic [KW-1:0] off_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               off_cnt <= '0;
    else if (st == ST_RETRY)  off_cnt <= off_cnt + 1'b1;
    else                      off_cnt <= '0;
  end

  // R3: a trip is always preceded by a qualified detect with power enabled
  a_r3_rise_needs_det: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> ($past(oc_s) && $past(pwr_en)));

  // R4: a retry off interval never exceeds its length
  a_r4_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    off_cnt <= KW'(RETRY_CYCLES));

  // R6: the latch holds while power stays enabled
  a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LATCH && pwr_en) |=> (st == ST_LATCH));

  // R7: power-save clears a trip at the next edge
  a_r7_pwr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !fault);

  // R7: standby follows power-save in the same cycle
  a_r7_stby_on_save: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_en || fault) |-> force_stby);
endmodule

bind ocp_guard ocp_guard_chk #(.RETRY_CYCLES(RETRY_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .oc_s(oc_sync),
  .fault(fault), .force_stby(force_stby), .st(state_q)
);

// File: tb/ocp_guard_tb.sv
module ocp_guard_tb;
  localparam int CLK_NS = 10;
  localparam int QW     = 4;
  localparam int RC     = 16;
  localparam int SS     = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          oc;
  logic          lsel;
  logic          pwr;
  logic [QW-1:0] lim;
  logic          stby;
  logic          flt;
  int            n_run = 0;
  int            n_fail = 0;

  always #(CLK_NS/2) clk = ~clk;

  ocp_guard #(.SYNC_STAGES(SS), .QUAL_W(QW), .RETRY_CYCLES(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .oc_det_raw(oc), .latch_sel(lsel),
    .pwr_en(pwr), .qual_limit(lim), .force_stby(stby), .fault(flt)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b (limit %0d)", req, act, exp, lim);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_all();
    oc = 1'b0;
    step(SS + 2);
    pwr = 1'b0;
    #1;
    chk("R7 standby with power-save", stby, 1'b1);
    step(1);
    chk("R7 fault cleared by power-save", flt, 1'b0);
    step(1);
    pwr = 1'b1;
    step(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; oc = 1'b0; lsel = 1'b0; pwr = 1'b1; lim = '0;
    step(3);
    chk("R1 fault in reset", flt, 1'b0);
    chk("R1 standby in reset", stby, 1'b0);
    rst_n = 1'b1;
    step(SS + 2);
    chk("R1 fault after reset", flt, 1'b0);
    chk("R1 standby after reset", stby, 1'b0);

    for (int l = 0; l < (1 << QW); l++) begin
      for (int m = 0; m < 2; m++) begin
        lim  = QW'(l);
        lsel = m[0];
        if (l > 0) begin
          oc = 1'b1;
          step(l);
          oc = 1'b0;
          step(SS + l + 3);
          chk("R2 short detect ignored", flt, 1'b0);
        end
        oc = 1'b1;
        step(l + 2);
        chk("R3 no trip before window", flt, 1'b0);
        step(1);
        chk("R3 trip at window end", flt, 1'b1);
        chk("R3 standby at trip", stby, 1'b1);
        if (m == 0) begin
          lsel = 1'b1;               // R8: flip policy during retry
          step(RC - 1);
          chk("R4 still off at last retry cycle", flt, 1'b1);
          lsel = 1'b0;
          step(1);
          chk("R4 R8 released after retry", flt, 1'b0);
          step(l);
          chk("R5 on-window before re-trip", flt, 1'b0);
          step(1);
          chk("R5 re-trip with persistent fault", flt, 1'b1);
        end else begin
          lsel = 1'b0;               // R8: flip policy during latch
          step(RC + 5);
          chk("R6 R8 latch holds with detect", flt, 1'b1);
          oc = 1'b0;
          step(SS + RC);
          chk("R6 latch holds after detect clears", flt, 1'b1);
        end
        clear_all();
      end
    end

    // R7: no qualification while power-save is active
    lim = '0;
    pwr = 1'b0;
    oc  = 1'b1;
    step(20);
    chk("R7 no trip during power-save", flt, 1'b0);
    chk("R7 standby during power-save", stby, 1'b1);
    pwr = 1'b1;
    step(1);
    chk("R7 qualification resumes after power-save", flt, 1'b1);
    clear_all();

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule